// File: doc/BRIEF.md
# Burst Transaction Trace Recorder

This block sits beside the memory masters of an AXI interconnect and observes their read and write channels without driving any of them. Each time a burst finishes, it builds one fixed-format completion record. The record holds the issuing master, the direction, the beat width, the number of beats, a cycle timestamp and, on the final burst of a request, the request's burst and byte totals. Records are pushed into an internal trace FIFO whose capacity is a parameter.

A host starts a capture by pulsing `arm`. This empties the FIFO, clears the overflow flag and begins recording. Recording ends when the host pulses `collect`, or by itself when the FIFO becomes full. The observed bus keeps running in either case, because every bus signal is an input to this block. The host then pops records oldest-first through a show-ahead read port and watches `empty` to know when it is done.

Each master's read and write channels are two separate record sources. Source index m is the read side of master m, and index NUM_MASTERS+m is its write side. Each source holds one pending record. A fixed-priority arbiter moves one pending record per cycle into the FIFO.

Top module: `burst_trace_rec`

## Requirements
- R1: A read burst completes on the R handshake (valid and ready) with rLast high. A write burst completes on the B handshake. Each completion yields exactly one record, and its type field is 2'b01 (burst done).
- R2: The record is 68 bits wide with this layout: [67:66] type, [65] direction (1 = write), [64:61] master index, [60:50] data width, [49:41] burst length, [40] request-total flag, [39:32] bursts in request, [31:16] bytes in request, [15:0] timestamp. The master index and direction match the channel that completed.
- R3: The data width field equals DATA_W. The burst length equals the number of beats in the burst. For reads this counts R handshakes up to and including the last one. For writes it counts the W handshakes, through wLast, that precede the B handshake.
- R4: A request ends when the request-end input (rReqEnd or bReqEnd) is high together with the completion. On that burst the flag is 1, the burst count is the number of bursts since the previous request end of the same source, and the byte count is the sum of their beats times DATA_W/8. On every other burst the flag and both totals are 0.
- R5: The timestamp is a free-running cycle counter. It is 0 during reset and rises by 1 each cycle. The record carries the counter value of the cycle in which the completion handshake occurs.
- R6: After reset, `recording` is 0, `empty` is 1 and `overflow` is 0.
- R7: An `arm` pulse discards all stored records, clears `overflow` and sets `recording` from the next cycle. Completions are stored only while `recording` is 1.
- R8: A `collect` pulse clears `recording`. Later completions are not stored, and they do not set `overflow`.
- R9: The FIFO holds DEPTH records. When it becomes full, `recording` drops to 0.
- R10: `overflow` is set when a completion is lost, either because the FIFO is full or because a source's pending record had not yet been taken. It then stays 1 until `arm` or reset.
- R11: `rdRecord` shows the oldest stored record. An `rdEn` pulse removes exactly one record. `rdEn` while `empty` is 1 has no effect.
- R12: When several sources complete in the same cycle, all records are stored, in ascending source index order (reads of masters 0..N-1, then writes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Pulse: clear FIFO and overflow, start recording |
| collect | input | 1 | Pulse: stop recording |
| rdEn | input | 1 | Pulse: pop the oldest record |
| rValid | input | NUM_MASTERS | Observed read data valid per master |
| rReady | input | NUM_MASTERS | Observed read data ready per master |
| rLast | input | NUM_MASTERS | Observed last read beat per master |
| rReqEnd | input | NUM_MASTERS | Read burst is the final one of its request |
| wValid | input | NUM_MASTERS | Observed write data valid per master |
| wReady | input | NUM_MASTERS | Observed write data ready per master |
| wLast | input | NUM_MASTERS | Observed last write beat per master |
| bValid | input | NUM_MASTERS | Observed write response valid per master |
| bReady | input | NUM_MASTERS | Observed write response ready per master |
| bReqEnd | input | NUM_MASTERS | Write burst is the final one of its request |
| rdRecord | output | 68 | Oldest stored record |
| empty | output | 1 | FIFO holds no record |
| overflow | output | 1 | Sticky: a completion was lost |
| recording | output | 1 | Capture is active |

## Verification
The record path is exercised by a table of bursts that mixes reads and writes across four masters. The bursts range from 1 to 16 beats, and the requests are built from one, two or three bursts. Mixing them separates correct per-source burst and byte accumulation from totals that leak between masters or directions, and shows that the flag appears only on the closing burst. Two masters completing in the same cycle distinguish the priority order and show that a simultaneous record is not lost. Directed runs fill the FIFO one record past its depth to separate stop-on-full from overflow reporting, and freeze a capture with `collect` to show that later bursts are neither stored nor counted as losses.

// File: rtl/trace_pkg.sv
package trace_pkg;
  localparam int ID_W    = 4;
  localparam int DW_W    = 11;
  localparam int LEN_W   = 9;
  localparam int CNT_W   = 8;
  localparam int BYTES_W = 16;
  localparam int TS_W    = 16;

  localparam logic [1:0] EV_BURST_DONE = 2'b01;

  typedef struct packed {
    logic [1:0]         evType;
    logic               isWrite;
    logic [ID_W-1:0]    masterId;
    logic [DW_W-1:0]    dataWidth;
    logic [LEN_W-1:0]   burstLen;
    logic               reqValid;
    logic [CNT_W-1:0]   burstsInReq;
    logic [BYTES_W-1:0] bytesInReq;
    logic [TS_W-1:0]    stamp;
  } trace_rec_t;

  localparam int REC_W = $bits(trace_rec_t);

  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } trace_strobe_t;
endpackage

// File: rtl/trace_port_track.sv
module trace_port_track
  import trace_pkg::*;
#(
  parameter bit IS_WRITE = 1'b0,
  parameter int DATA_W   = 64,
  parameter int MID      = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             beatFire,
  input  logic             beatLast,
  input  logic             doneFire,
  input  logic             reqEnd,
  input  logic [TS_W-1:0]  ts,
  input  logic             grant,
  output logic             pendValid,
  output trace_rec_t       pendRec,
  output logic             drop
);
  localparam int BPB = DATA_W / 8;

  logic [LEN_W-1:0]   beatCnt, lenHold, curLen;
  logic [CNT_W-1:0]   burstCnt;
  logic [BYTES_W-1:0] byteAcc, newBytes;
  trace_rec_t         newRec;

  always_comb begin
    curLen   = IS_WRITE ? lenHold : beatCnt + 1'b1;
    newBytes = byteAcc + BYTES_W'(curLen) * BYTES_W'(BPB);
    newRec             = '0;
    newRec.evType      = EV_BURST_DONE;
    newRec.isWrite     = IS_WRITE;
    newRec.masterId    = ID_W'(MID);
    newRec.dataWidth   = DW_W'(DATA_W);
    newRec.burstLen    = curLen;
    newRec.stamp       = ts;
    if (reqEnd) begin
      newRec.reqValid    = 1'b1;
      newRec.burstsInReq = burstCnt + 1'b1;
      newRec.bytesInReq  = newBytes;
    end
  end

  assign drop = doneFire && pendValid && !grant;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beatCnt   <= '0;
      lenHold   <= '0;
      burstCnt  <= '0;
      byteAcc   <= '0;
      pendValid <= 1'b0;
      pendRec   <= '0;
    end else begin
      if (beatFire) begin
        if (beatLast) begin
          beatCnt <= '0;
          lenHold <= beatCnt + 1'b1;
        end else begin
          beatCnt <= beatCnt + 1'b1;
        end
      end
      if (doneFire) begin
        pendRec <= newRec;
        if (reqEnd) begin
          burstCnt <= '0;
          byteAcc  <= '0;
        end else begin
          burstCnt <= burstCnt + 1'b1;
          byteAcc  <= newBytes;
        end
      end
      pendValid <= doneFire || (pendValid && !grant);
    end
  end

  // R1: every completion leaves a pending record behind
  a_r1_done_pending: assert property (@(posedge clk) disable iff (!rstN)
    doneFire |=> pendValid);
  // R4: a non-final burst never carries request totals
  a_r4_flag_final_only: assert property (@(posedge clk) disable iff (!rstN)
    (doneFire && !reqEnd) |=> (!pendRec.reqValid && pendRec.bytesInReq == '0));
endmodule

// File: rtl/trace_ctrl.sv
module trace_ctrl
  import trace_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          arm,
  input  logic          collect,
  input  logic          hostRd,
  input  logic          full,
  input  logic          empty,
  input  logic          anyPend,
  input  logic          evDone,
  input  logic          drop,
  output trace_strobe_t strb,
  output logic          recording,
  output logic          overflow
);
  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_HALTED, ST_FULL} cap_state_e;
  cap_state_e st;
  logic ovfSet;

  assign recording  = (st == ST_ARMED);
  assign strb.push  = recording && anyPend && !full;
  assign strb.pop   = hostRd && !empty;
  assign strb.clear = arm;

  assign ovfSet = (recording && full && anyPend) ||
                  (recording && drop) ||
                  (st == ST_FULL && evDone);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      overflow <= 1'b0;
    end else begin
      if (arm) begin
        st <= ST_ARMED;
      end else if (st == ST_ARMED) begin
        if (collect)   st <= ST_HALTED;
        else if (full) st <= ST_FULL;
      end
      if (arm)         overflow <= 1'b0;
      else if (ovfSet) overflow <= 1'b1;
    end
  end

  // R10: overflow stays set until the next arm
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !arm) |=> overflow);
  // R8: a halted capture stays halted until re-armed
  a_r8_halt_holds: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_HALTED && !arm) |=> !recording);
  // R7: arm always starts recording in the next cycle
  a_r7_arm_starts: assert property (@(posedge clk) disable iff (!rstN)
    arm |=> recording);
endmodule

// File: rtl/trace_datapath.sv
module trace_datapath
  import trace_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int DATA_W      = 64,
  parameter int DEPTH       = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  trace_strobe_t          strb,
  input  logic [NUM_MASTERS-1:0] rValid,
  input  logic [NUM_MASTERS-1:0] rReady,
  input  logic [NUM_MASTERS-1:0] rLast,
  input  logic [NUM_MASTERS-1:0] rReqEnd,
  input  logic [NUM_MASTERS-1:0] wValid,
  input  logic [NUM_MASTERS-1:0] wReady,
  input  logic [NUM_MASTERS-1:0] wLast,
  input  logic [NUM_MASTERS-1:0] bValid,
  input  logic [NUM_MASTERS-1:0] bReady,
  input  logic [NUM_MASTERS-1:0] bReqEnd,
  output logic [REC_W-1:0]       rdRecord,
  output logic                   full,
  output logic                   empty,
  output logic                   anyPend,
  output logic                   evDone,
  output logic                   drop
);
  localparam int SRC = 2 * NUM_MASTERS;
  localparam int AW  = $clog2(DEPTH);

  logic [SRC-1:0]  pend, grant, doneVec, dropVec;
  trace_rec_t      recs [SRC];
  trace_rec_t      selRec;
  logic [TS_W-1:0] tsCnt;
  logic [AW:0]     wPtr, rPtr;
  trace_rec_t      mem [DEPTH];

  for (genvar i = 0; i < SRC; i++) begin : g_src
    localparam int M   = i % NUM_MASTERS;
    localparam bit ISW = (i >= NUM_MASTERS);
    logic bf, bl, df, re;
    if (ISW) begin : g_wr
      assign bf = wValid[M] & wReady[M];
      assign bl = wLast[M];
      assign df = bValid[M] & bReady[M];
      assign re = bReqEnd[M];
    end else begin : g_rd
      assign bf = rValid[M] & rReady[M];
      assign bl = rLast[M];
      assign df = bf & rLast[M];
      assign re = rReqEnd[M];
    end
    assign doneVec[i] = df;
    trace_port_track #(.IS_WRITE(ISW), .DATA_W(DATA_W), .MID(M)) u_trk (
      .clk(clk), .rstN(rstN), .beatFire(bf), .beatLast(bl), .doneFire(df),
      .reqEnd(re), .ts(tsCnt), .grant(grant[i]), .pendValid(pend[i]),
      .pendRec(recs[i]), .drop(dropVec[i]));
  end

  always_comb begin
    grant  = '0;
    selRec = '0;
    for (int i = SRC - 1; i >= 0; i--) begin
      if (pend[i]) grant = SRC'(1) << i;
    end
    for (int i = 0; i < SRC; i++) begin
      if (grant[i]) selRec = recs[i];
    end
  end

  assign anyPend  = |pend;
  assign evDone   = |doneVec;
  assign drop     = |dropVec;
  assign empty    = (wPtr == rPtr);
  assign full     = (wPtr[AW] != rPtr[AW]) && (wPtr[AW-1:0] == rPtr[AW-1:0]);
  assign rdRecord = mem[rPtr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tsCnt <= '0;
      wPtr  <= '0;
      rPtr  <= '0;
    end else begin
      tsCnt <= tsCnt + 1'b1;
      if (strb.clear) begin
        wPtr <= '0;
        rPtr <= '0;
      end else begin
        if (strb.push) wPtr <= wPtr + 1'b1;
        if (strb.pop)  rPtr <= rPtr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.push) mem[wPtr[AW-1:0]] <= selRec;
  end

  // R9: control never pushes into a full FIFO
  a_r9_no_push_full: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !strb.push);
  // R11: control never pops an empty FIFO
  a_r11_pop_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> !empty);
  // R12: at most one source is served per cycle
  a_r12_grant_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));
  // R5: timestamp advances by exactly one each cycle
  a_r5_ts_step: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> tsCnt == TS_W'($past(tsCnt) + 1'b1));
endmodule

// File: rtl/burst_trace_rec.sv
module burst_trace_rec
  import trace_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int DATA_W      = 64,
  parameter int DEPTH       = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   arm,
  input  logic                   collect,
  input  logic                   rdEn,
  input  logic [NUM_MASTERS-1:0] rValid,
  input  logic [NUM_MASTERS-1:0] rReady,
  input  logic [NUM_MASTERS-1:0] rLast,
  input  logic [NUM_MASTERS-1:0] rReqEnd,
  input  logic [NUM_MASTERS-1:0] wValid,
  input  logic [NUM_MASTERS-1:0] wReady,
  input  logic [NUM_MASTERS-1:0] wLast,
  input  logic [NUM_MASTERS-1:0] bValid,
  input  logic [NUM_MASTERS-1:0] bReady,
  input  logic [NUM_MASTERS-1:0] bReqEnd,
  output logic [REC_W-1:0]       rdRecord,
  output logic                   empty,
  output logic                   overflow,
  output logic                   recording
);
  trace_strobe_t strb;
  logic full, anyPend, evDone, drop;

  trace_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .arm(arm), .collect(collect), .hostRd(rdEn),
    .full(full), .empty(empty), .anyPend(anyPend), .evDone(evDone),
    .drop(drop), .strb(strb), .recording(recording), .overflow(overflow));

  trace_datapath #(.NUM_MASTERS(NUM_MASTERS), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rValid(rValid), .rReady(rReady), .rLast(rLast), .rReqEnd(rReqEnd),
    .wValid(wValid), .wReady(wReady), .wLast(wLast),
    .bValid(bValid), .bReady(bReady), .bReqEnd(bReqEnd),
    .rdRecord(rdRecord), .full(full), .empty(empty),
    .anyPend(anyPend), .evDone(evDone), .drop(drop));
endmodule

// File: tb/tb_burst_trace_rec.sv
`timescale 1ns/1ps
module tb_burst_trace_rec;
  localparam int NM = 4;
  localparam int DEPTH = 8;
  localparam int BPB = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic arm = 0, collect = 0, rdEn = 0;
  logic [NM-1:0] rValid = '0, rReady = '0, rLast = '0, rReqEnd = '0;
  logic [NM-1:0] wValid = '0, wReady = '0, wLast = '0;
  logic [NM-1:0] bValid = '0, bReady = '0, bReqEnd = '0;
  logic [67:0] rdRecord;
  logic empty, overflow, recording;

  int checks = 0, errors = 0;
  int bCyc = 0;
  int mBursts [2][NM];
  int mBytes  [2][NM];

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) bCyc <= 0;
    else       bCyc <= bCyc + 1;
  end

  burst_trace_rec #(.NUM_MASTERS(NM), .DATA_W(64), .DEPTH(DEPTH)) dut (.*);

  typedef struct packed {
    logic [1:0] m;
    logic       isW;
    logic [4:0] beats;
    logic       reqEnd;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 1'b0, 5'd4,  1'b1},
    '{2'd1, 1'b1, 5'd2,  1'b0},
    '{2'd1, 1'b1, 5'd3,  1'b1},
    '{2'd2, 1'b0, 5'd1,  1'b1},
    '{2'd3, 1'b0, 5'd16, 1'b0},
    '{2'd3, 1'b0, 5'd16, 1'b0},
    '{2'd3, 1'b0, 5'd8,  1'b1},
    '{2'd0, 1'b1, 5'd1,  1'b1}
  };

  task automatic chk(input string tag, input logic [67:0] act, input logic [67:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [67:0] expRec(input int m, input bit isW, input int beats,
                                         input bit reqEnd, input int ts);
    int d = isW ? 1 : 0;
    logic [7:0] bu = '0;
    logic [15:0] by = '0;
    if (reqEnd) begin
      bu = 8'(mBursts[d][m] + 1);
      by = 16'(mBytes[d][m] + beats * BPB);
      mBursts[d][m] = 0;
      mBytes[d][m] = 0;
    end else begin
      mBursts[d][m] += 1;
      mBytes[d][m] += beats * BPB;
    end
    return {2'b01, isW, 4'(m), 11'd64, 9'(beats), reqEnd, bu, by, 16'(ts)};
  endfunction

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) arm = 1; else if (which == 1) collect = 1; else rdEn = 1;
    @(negedge clk);
    arm = 0; collect = 0; rdEn = 0;
  endtask

  task automatic doBurst(input int m, input bit isW, input int beats,
                         input bit reqEnd, output int ts);
    for (int b = 0; b < beats; b++) begin
      @(negedge clk);
      if (isW) begin
        wValid[m] = 1; wReady[m] = 1; wLast[m] = (b == beats - 1);
      end else begin
        rValid[m] = 1; rReady[m] = 1; rLast[m] = (b == beats - 1);
        if (b == beats - 1) begin rReqEnd[m] = reqEnd; ts = bCyc; end
      end
    end
    @(negedge clk);
    rValid = '0; rReady = '0; rLast = '0; rReqEnd = '0;
    wValid = '0; wReady = '0; wLast = '0;
    if (isW) begin
      bValid[m] = 1; bReady[m] = 1; bReqEnd[m] = reqEnd; ts = bCyc;
      @(negedge clk);
      bValid = '0; bReady = '0; bReqEnd = '0;
    end
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int ts, ts2;
    logic [67:0] e1, e2;
    logic [67:0] fullExp [9];
    for (int d = 0; d < 2; d++)
      for (int m = 0; m < NM; m++) begin mBursts[d][m] = 0; mBytes[d][m] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R6 reset recording", 68'(recording), 68'(0));
    chk("R6 reset empty", 68'(empty), 68'(1));
    chk("R6 reset overflow", 68'(overflow), 68'(0));

    pulse(0);
    chk("R7 arm sets recording", 68'(recording), 68'(1));

    // table walk: R1 R2 R3 R4 R5
    for (int v = 0; v < 8; v++) begin
      doBurst(VECS[v].m, VECS[v].isW, VECS[v].beats, VECS[v].reqEnd, ts);
      e1 = expRec(VECS[v].m, VECS[v].isW, VECS[v].beats, VECS[v].reqEnd, ts);
      repeat (3) @(negedge clk);
      chk("R1 record present", 68'(empty), 68'(0));
      chk("R1 R2 R3 R4 R5 record", rdRecord, e1);
      pulse(2);
      chk("R11 pop one", 68'(empty), 68'(1));
    end

    // R11: pop while empty is ignored
    pulse(2);
    doBurst(2, 1'b0, 3, 1'b1, ts);
    e1 = expRec(2, 1'b0, 3, 1'b1, ts);
    repeat (3) @(negedge clk);
    chk("R11 empty pop ignored", rdRecord, e1);
    pulse(2);

    // R12: two masters complete in the same cycle
    @(negedge clk);
    rValid = 4'b0110; rReady = 4'b0110; rLast = 4'b0110; rReqEnd = 4'b0110; ts = bCyc;
    @(negedge clk);
    rValid = '0; rReady = '0; rLast = '0; rReqEnd = '0;
    e1 = expRec(1, 1'b0, 1, 1'b1, ts);
    e2 = expRec(2, 1'b0, 1, 1'b1, ts);
    repeat (3) @(negedge clk);
    chk("R12 first lower index", rdRecord, e1);
    pulse(2);
    chk("R12 second record", rdRecord, e2);
    pulse(2);
    chk("R12 drained", 68'(empty), 68'(1));
    chk("R10 no loss on simultaneous", 68'(overflow), 68'(0));

    // R8: collect freezes capture
    pulse(0);
    doBurst(0, 1'b1, 2, 1'b1, ts);
    e1 = expRec(0, 1'b1, 2, 1'b1, ts);
    repeat (2) @(negedge clk);
    pulse(1);
    chk("R8 collect clears recording", 68'(recording), 68'(0));
    doBurst(3, 1'b0, 2, 1'b1, ts2);
    e2 = expRec(3, 1'b0, 2, 1'b1, ts2);
    repeat (3) @(negedge clk);
    chk("R8 pre-collect record kept", rdRecord, e1);
    pulse(2);
    chk("R8 post-collect burst not stored", 68'(empty), 68'(1));
    chk("R8 no overflow after collect", 68'(overflow), 68'(0));

    // R9 R10: fill past depth
    pulse(0);
    chk("R7 arm leaves FIFO empty", 68'(empty), 68'(1));
    for (int k = 0; k < DEPTH + 1; k++) begin
      doBurst(1, 1'b0, 1, 1'b1, ts);
      fullExp[k] = expRec(1, 1'b0, 1, 1'b1, ts);
      repeat (2) @(negedge clk);
      if (k == DEPTH - 1) begin
        chk("R9 recording stops at full", 68'(recording), 68'(0));
        chk("R10 no overflow at exact full", 68'(overflow), 68'(0));
      end
    end
    chk("R10 overflow after loss", 68'(overflow), 68'(1));
    for (int k = 0; k < DEPTH; k++) begin
      chk($sformatf("R9 R11 stored record %0d", k), rdRecord, fullExp[k]);
      pulse(2);
    end
    chk("R9 depth records only", 68'(empty), 68'(1));
    chk("R10 overflow sticky", 68'(overflow), 68'(1));
    pulse(0);
    chk("R7 arm clears overflow", 68'(overflow), 68'(0));
    chk("R7 re-arm recording", 68'(recording), 68'(1));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule